// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block is a synchronous controller that produces the system reset. It merges three causes: a supply-low flag coming from an external voltage comparator, an active-low manual reset pin, and a watchdog that expects the software to toggle a strobe line. While any level cause is present, reset is held. Once the last cause has gone, reset is stretched for a fixed number of clock cycles. Reset is driven on two outputs of opposite polarity.

The manual reset pin and the strobe pin each pass through a two-flop synchroniser. The manual reset path then goes through a sample filter, so that a short low glitch cannot start a reset. The watchdog counter restarts on either edge of the synchronised strobe. It is held at zero for as long as reset is asserted. A "strobe undriven" indication stops the counter, so the watchdog cannot expire while that indication is set.

The sequencing is done by a three-state machine:
- `ST_HOLD`: a level cause (supply low, or the filtered manual reset) is present.
- `ST_STRETCH`: the stretch counter runs.
- `ST_RUN`: reset is released.

The transitions are:
- `HOLD→STRETCH`: all level causes have cleared.
- `STRETCH→HOLD`: a level cause returns.
- `STRETCH→RUN`: the stretch count is complete.
- `RUN→HOLD`: a level cause appears.
- `RUN→STRETCH`: the watchdog expires.

The block's asynchronous reset puts the machine in `ST_STRETCH` with the count at zero.

Top module: `rst_supervisor`

## Requirements
- R1: `supply_low_i` high at a clock edge makes `sys_rst_o` high from that edge on, and keeps it high while the flag stays high.
- R2: When `man_rst_n_i` is held low, `sys_rst_o` rises MR_FILT+3 clock edges after the first edge that samples the low level (2 synchroniser stages, MR_FILT filter samples, 1 edge for the state machine).
- R3: A low pulse on `man_rst_n_i` lasting MR_FILT-1 clock cycles or fewer causes no reset.
- R4: With the strobe held constant and the undriven indication low, the watchdog counts WD_CYC clock edges of released reset and then expires. `sys_rst_o` rises on the edge after the expiry.
- R5: Either edge of `strobe_i` restarts the watchdog count. The restart takes effect on the third clock edge after the new strobe level is applied.
- R6: While `strobe_undriven_i` is high, the watchdog never expires and never causes a reset.
- R7: After the last level cause clears, `sys_rst_o` stays high for STRETCH_CYC more clock edges after the edge that enters `ST_STRETCH`, then falls.
- R8: A level cause that arrives during the stretch returns the machine to `ST_HOLD`. A full stretch period restarts when that cause clears.
- R9: Any reset clears the watchdog count. Counting starts again only once reset is released.
- R10: After the asynchronous block reset `arst_n` is released, `sys_rst_o` is high and falls on the STRETCH_CYC-th clock edge.
- R11: `sys_rst_n_o` is always the complement of `sys_rst_o`.
- R12: A reset caused by the watchdog alone lasts exactly STRETCH_CYC clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous block reset, active low |
| supply_low_i | input | 1 | Supply-below-threshold flag, synchronous to `clk` |
| man_rst_n_i | input | 1 | Manual reset request, active low, asynchronous |
| strobe_i | input | 1 | Watchdog strobe, asynchronous; either edge services the watchdog |
| strobe_undriven_i | input | 1 | High when the strobe line is not driven; disables the watchdog |
| sys_rst_n_o | output | 1 | System reset, active low |
| sys_rst_o | output | 1 | System reset, active high |

## Verification
The bench builds the block with STRETCH_CYC=20, WD_CYC=50 and MR_FILT=8. With these values every timeout fits in a few dozen cycles, so the exact edge on which each output changes can be checked for all causes. The checked cases are:
- the power-on stretch;
- the supply-low stretch, and its restart when a cause returns mid-stretch;
- the filter boundary at MR_FILT-1 versus MR_FILT low samples;
- the watchdog expiry edge and its exact pulse length;
- repeated servicing by strobe toggles, with the expiry timed from the last toggle;
- the watchdog restarting its count from zero after a supply-low reset.

// File: rtl/rsup_pkg.sv
package rsup_pkg;
    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_STRETCH = 2'd1,
        ST_RUN     = 2'd2
    } rsup_state_e;
endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rsup_mr_filter.sv
module rsup_mr_filter #(
    parameter int FILT = 8
) (
    input  logic clk,
    input  logic arst_n,
    input  logic lvl_n_i,
    output logic act_o
);
    localparam int CW = $clog2(FILT + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT - 1);

    logic [CW-1:0] low_cnt_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            low_cnt_q <= '0;
            act_o     <= 1'b0;
        end else if (lvl_n_i) begin
            low_cnt_q <= '0;
            act_o     <= 1'b0;
        end else if (low_cnt_q == LAST) begin
            act_o     <= 1'b1;
        end else begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rsup_wdog.sv
module rsup_wdog #(
    parameter int WD_CYC = 50,
    localparam int CW = $clog2(WD_CYC + 1)
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          strobe_s_i,
    input  logic          hold_i,
    input  logic          off_i,
    output logic          exp_o,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] LAST = CW'(WD_CYC - 1);

    logic prev_q;
    logic toggled;

    assign toggled = strobe_s_i ^ prev_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            prev_q <= 1'b0;
            cnt_o  <= '0;
            exp_o  <= 1'b0;
        end else begin
            prev_q <= strobe_s_i;
            exp_o  <= 1'b0;
            if (hold_i || off_i || toggled) begin
                cnt_o <= '0;
            end else if (cnt_o == LAST) begin
                cnt_o <= '0;
                exp_o <= 1'b1;
            end else begin
                cnt_o <= cnt_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
    import rsup_pkg::*;
#(
    parameter int STRETCH_CYC = 4000000,
    parameter int WD_CYC      = 32000000,
    parameter int MR_FILT     = 10
) (
    input  logic clk,
    input  logic arst_n,
    input  logic supply_low_i,
    input  logic man_rst_n_i,
    input  logic strobe_i,
    input  logic strobe_undriven_i,
    output logic sys_rst_n_o,
    output logic sys_rst_o
);
    localparam int SW = $clog2(STRETCH_CYC + 1);
    localparam int WW = $clog2(WD_CYC + 1);
    localparam logic [SW-1:0] ST_LAST = SW'(STRETCH_CYC - 1);

    rsup_state_e   state_q, state_d;
    logic [SW-1:0] st_cnt_q;
    logic          mr_lvl, mr_act, strobe_s, wd_exp, lvl_cause;
    logic [WW-1:0] wd_cnt;

    rsup_sync #(.STAGES(2), .RST_VAL(1'b1)) u_mr_sync (
        .clk(clk), .arst_n(arst_n), .d_i(man_rst_n_i), .q_o(mr_lvl)
    );

    rsup_sync #(.STAGES(2), .RST_VAL(1'b0)) u_wd_sync (
        .clk(clk), .arst_n(arst_n), .d_i(strobe_i), .q_o(strobe_s)
    );

    rsup_mr_filter #(.FILT(MR_FILT)) u_mr_filt (
        .clk(clk), .arst_n(arst_n), .lvl_n_i(mr_lvl), .act_o(mr_act)
    );

    rsup_wdog #(.WD_CYC(WD_CYC)) u_wdog (
        .clk(clk), .arst_n(arst_n), .strobe_s_i(strobe_s),
        .hold_i(sys_rst_o), .off_i(strobe_undriven_i),
        .exp_o(wd_exp), .cnt_o(wd_cnt)
    );

    assign lvl_cause = supply_low_i | mr_act;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:    if (!lvl_cause) state_d = ST_STRETCH;
            ST_STRETCH: begin
                if (lvl_cause)                  state_d = ST_HOLD;
                else if (st_cnt_q == ST_LAST)   state_d = ST_RUN;
            end
            ST_RUN: begin
                if (lvl_cause)   state_d = ST_HOLD;
                else if (wd_exp) state_d = ST_STRETCH;
            end
            default:             state_d = ST_HOLD;
        endcase
    end

    // state register and stretch counter
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q  <= ST_STRETCH;
            st_cnt_q <= '0;
        end else begin
            state_q  <= state_d;
            st_cnt_q <= (state_q == ST_STRETCH) ? st_cnt_q + 1'b1 : '0;
        end
    end

    // outputs
    always_comb begin
        sys_rst_o   = (state_q != ST_RUN);
        sys_rst_n_o = (state_q == ST_RUN);
    end
endmodule

// File: rtl/rsup_checker.sv
module rsup_checker #(
    parameter int STRETCH_CYC = 20,
    parameter int WD_CYC      = 50,
    localparam int SW = $clog2(STRETCH_CYC + 1),
    localparam int WW = $clog2(WD_CYC + 1)
) (
    input logic          clk,
    input logic          arst_n,
    input logic          supply_low_i,
    input logic          strobe_undriven_i,
    input logic          sys_rst_o,
    input logic          sys_rst_n_o,
    input logic          mr_lvl,
    input logic          mr_act,
    input logic          wd_exp,
    input logic [WW-1:0] wd_cnt,
    input logic [SW-1:0] st_cnt
);
    assert_supply_low_R1: assert property (@(posedge clk) disable iff (!arst_n)
        supply_low_i |=> sys_rst_o);

    assert_filter_low_R2: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(mr_act) |-> !$past(mr_lvl));

    assert_wd_range_R4: assert property (@(posedge clk) disable iff (!arst_n)
        wd_cnt < WD_CYC);

    assert_wd_to_reset_R4: assert property (@(posedge clk) disable iff (!arst_n)
        wd_exp |=> sys_rst_o);

    assert_wd_off_R6: assert property (@(posedge clk) disable iff (!arst_n)
        strobe_undriven_i |=> !wd_exp);

    assert_stretch_done_R7: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(sys_rst_o) |-> ($past(st_cnt) == SW'(STRETCH_CYC - 1)));

    assert_wd_cleared_R9: assert property (@(posedge clk) disable iff (!arst_n)
        sys_rst_o |=> (wd_cnt == '0));

    assert_polarity_R11: assert property (@(posedge clk) disable iff (!arst_n)
        sys_rst_n_o == !sys_rst_o);
endmodule

bind rst_supervisor rsup_checker #(
    .STRETCH_CYC(STRETCH_CYC),
    .WD_CYC(WD_CYC)
) u_chk (
    .clk(clk), .arst_n(arst_n), .supply_low_i(supply_low_i),
    .strobe_undriven_i(strobe_undriven_i), .sys_rst_o(sys_rst_o),
    .sys_rst_n_o(sys_rst_n_o), .mr_lvl(mr_lvl), .mr_act(mr_act),
    .wd_exp(wd_exp), .wd_cnt(wd_cnt), .st_cnt(st_cnt_q)
);

// File: tb/sim_rst_supervisor.sv
module sim_rst_supervisor;
    localparam int STRETCH = 20;
    localparam int WD      = 50;
    localparam int FILT    = 8;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic supply_low = 1'b0;
    logic mr_n = 1'b1;
    logic strobe = 1'b0;
    logic undriven = 1'b1;
    logic rst_n_o, rst_o;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    rst_supervisor #(.STRETCH_CYC(STRETCH), .WD_CYC(WD), .MR_FILT(FILT)) u0 (
        .clk(clk), .arst_n(arst_n), .supply_low_i(supply_low),
        .man_rst_n_i(mr_n), .strobe_i(strobe), .strobe_undriven_i(undriven),
        .sys_rst_n_o(rst_n_o), .sys_rst_o(rst_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_rst(input logic exp_v, input string req);
        n_checks++;
        if (rst_o !== exp_v || rst_n_o !== ~exp_v) begin
            n_fail++;
            $display("FAIL %s: rst=%b rst_n=%b expected rst=%b rst_n=%b",
                     req, rst_o, rst_n_o, exp_v, ~exp_v);
        end
    endtask

    task automatic expect_quiet(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            tick(1);
            if (rst_o !== 1'b0) seen++;
        end
        n_checks++;
        if (seen != 0) begin
            n_fail++;
            $display("FAIL %s: reset high in %0d cycles, expected 0", req, seen);
        end
    endtask

    task automatic t_power_on;
        tick(3);
        expect_rst(1'b1, "R10 during block reset");
        arst_n = 1'b1;
        tick(19);
        expect_rst(1'b1, "R10 last stretch cycle");
        tick(1);
        expect_rst(1'b0, "R10 released");
        expect_rst(1'b0, "R11 polarity");
    endtask

    task automatic t_supply_low;
        supply_low = 1'b1;
        tick(1);
        expect_rst(1'b1, "R1 assert");
        tick(5);
        expect_rst(1'b1, "R1 held");
        supply_low = 1'b0;
        tick(20);
        expect_rst(1'b1, "R7 stretch end");
        tick(1);
        expect_rst(1'b0, "R7 release");
    endtask

    task automatic t_restart;
        supply_low = 1'b1;
        tick(3);
        supply_low = 1'b0;
        tick(10);
        expect_rst(1'b1, "R8 mid stretch");
        supply_low = 1'b1;
        tick(3);
        supply_low = 1'b0;
        tick(20);
        expect_rst(1'b1, "R8 restarted stretch");
        tick(1);
        expect_rst(1'b0, "R8 release");
    endtask

    task automatic t_mr_glitch;
        mr_n = 1'b0;
        tick(FILT - 1);
        mr_n = 1'b1;
        expect_quiet(30, "R3 glitch ignored");
    endtask

    task automatic t_mr_hold;
        mr_n = 1'b0;
        tick(FILT + 2);
        expect_rst(1'b0, "R2 before filter done");
        tick(1);
        expect_rst(1'b1, "R2 asserted");
        tick(5);
        mr_n = 1'b1;
        tick(23);
        expect_rst(1'b1, "R7 manual stretch end");
        tick(1);
        expect_rst(1'b0, "R7 manual release");
    endtask

    task automatic t_undriven;
        undriven = 1'b1;
        expect_quiet(200, "R6 watchdog disabled");
    endtask

    task automatic t_watchdog;
        undriven = 1'b0;
        tick(50);
        expect_rst(1'b0, "R4 before expiry");
        tick(1);
        expect_rst(1'b1, "R4 expiry");
        tick(19);
        expect_rst(1'b1, "R12 pulse end");
        tick(1);
        expect_rst(1'b0, "R12 pulse length");
        for (int k = 0; k < 6; k++) begin
            tick(30);
            strobe = ~strobe;
        end
        n_checks++;
        if (rst_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R5 serviced: rst=%b expected 0", rst_o);
        end
        tick(53);
        expect_rst(1'b0, "R5 before expiry after last edge");
        tick(1);
        expect_rst(1'b1, "R5 expiry after last edge");
        tick(20);
        expect_rst(1'b0, "R12 second pulse over");
        tick(20);
        supply_low = 1'b1;
        tick(3);
        supply_low = 1'b0;
        tick(71);
        expect_rst(1'b0, "R9 count restarted");
        tick(1);
        expect_rst(1'b1, "R9 expiry from zero");
        undriven = 1'b1;
        tick(25);
        expect_rst(1'b0, "R6 quiet after disable");
    endtask

    initial begin
        t_power_on();
        t_supply_low();
        t_restart();
        t_mr_glitch();
        t_mr_hold();
        t_undriven();
        t_watchdog();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: bench timed out, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule